// File: doc/BRIEF.md
# Token Ring Sparsified Hit Readout

This block collects time-stamped hits from 32 channels and ships them out as a byte stream. Every channel has a small first-in first-out buffer of four hit slots. A single token moves through the channels and visits only those that hold at least one hit. The visited buffer gives up its oldest entry. That entry becomes a 32-bit word tagged with the channel number. A serializer then sends the word as four bytes on a link that runs four times faster than the readout logic.

The whole block runs on the fast link clock. A `core_tick` strobe marks one fast cycle in every four, and those cycles form the slower main-clock rate. Channel writes, buffer pops and token moves all happen only on cycles where `core_tick` is high. The serializer puts out one byte on every fast cycle. With a steady tick, the link carries one complete word per main-clock period with no idle gaps. Channels that are empty use no link bandwidth.

Top module: `token_readout`

## Requirements
- R1: After synchronous reset, `pkt_valid` is low, `pkt_data` is 8'h00, and every `fifo_full` and `ovf_flag` bit is low.
- R2: Each word is {bit31 = 1 marker, bits30:26 = channel number, bits25:24 = 2'b00, bits23:10 = 14-bit stamp, bits9:0 = 0}. The word is sent most-significant byte first, one byte per fast cycle.
- R3: On any cycle with no byte to send, `pkt_valid` is low and `pkt_data` is 8'h00.
- R4: Only channels holding at least one hit are read. Every accepted hit is sent exactly once, and no word is produced without a stored hit.
- R5: On a readout step, the token searches upward from the channel after the one it last served, wrapping from 31 to 0, and serves the first non-empty channel in one step. After reset the search starts at channel 0.
- R6: Hits from one channel leave in the order they were written.
- R7: `fifo_full[c]` is high exactly when channel c holds 4 hits.
- R8: A write to a channel whose buffer is full at that tick is dropped, even if the same tick pops that channel. The write sets `ovf_flag[c]`, and the flag stays set until reset.
- R9: The four bytes of a word appear on four consecutive fast cycles with `pkt_valid` high.
- R10: A buffer is popped only on a `core_tick` cycle when the serializer has at most one byte of its current word left. A tick that arrives earlier moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast link clock |
| rst | input | 1 | Synchronous active-high reset |
| core_tick | input | 1 | One-cycle strobe marking a main-clock step |
| wr_en | input | 32 | Per-channel hit write strobe, sampled on `core_tick` cycles |
| wr_stamp | input | 448 | Per-channel 14-bit stamps; channel c uses bits [14c+13:14c] |
| pkt_data | output | 8 | Output byte, 8'h00 when idle |
| pkt_valid | output | 1 | High while `pkt_data` carries a byte |
| fifo_full | output | 32 | Per-channel buffer-full flag |
| ovf_flag | output | 32 | Per-channel sticky flag for dropped writes |

## Verification
The embedded properties assume that `wr_en` is only meaningful on `core_tick` cycles. They also assume that `core_tick` is never asserted during reset, and that a pop request comes only from the arbiter while the serializer is ready. The stimulus changes inputs only on falling edges and drives hits together with a tick. It keeps a regular one-in-four tick rhythm, except in one phase that places ticks 1, 2, 3 and 5 cycles apart to exercise serializer back-pressure. A reference model in the bench holds per-channel queues, the token position and the serializer occupancy. From these it predicts every word, full flag and overflow flag.

// File: rtl/tr_pkg.sv
package tr_pkg;
    localparam int NCH_D    = 32;
    localparam int STAMP_WD = 14;
    localparam int DEPTH_D  = 4;
    localparam int PKT_WD   = 8;
    localparam int CH_WD    = $clog2(NCH_D);

    typedef struct packed {
        logic                mark;
        logic [CH_WD-1:0]    chan;
        logic [1:0]          rsv;
        logic [STAMP_WD-1:0] stamp;
        logic [9:0]          pad;
    } hit_word_t;

    localparam int WORD_WD = $bits(hit_word_t);

    function automatic hit_word_t pack_hit(input logic [CH_WD-1:0] ch,
                                           input logic [STAMP_WD-1:0] st);
        hit_word_t w;
        w.mark  = 1'b1;
        w.chan  = ch;
        w.rsv   = 2'b00;
        w.stamp = st;
        w.pad   = '0;
        return w;
    endfunction
endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
    parameter int DEPTH = tr_pkg::DEPTH_D,
    parameter int W     = tr_pkg::STAMP_WD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          accept;

    assign full   = (cnt == (AW+1)'(DEPTH));
    assign empty  = (cnt == '0);
    assign accept = wr && !full;
    assign rdata  = mem[rp];

    always_ff @(posedge clk) begin
        if (accept) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (accept) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (rd)     rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            unique case ({accept, rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (wr && full) ovf <= 1'b1;
        end
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        rd |-> !empty);
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= (AW+1)'(DEPTH));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
endmodule

// File: rtl/token_arbiter.sv
module token_arbiter #(
    parameter int NCH  = tr_pkg::NCH_D,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [NCH-1:0]  nonempty,
    output logic [NCH-1:0]  pop,
    output logic            gvalid,
    output logic [CH_W-1:0] gch
);
    logic [CH_W-1:0] ptr;

    always_comb begin
        gvalid = 1'b0;
        gch    = ptr;
        for (int i = 1; i <= NCH; i++) begin
            int idx;
            idx = (int'(ptr) + i) % NCH;
            if (!gvalid && nonempty[idx]) begin
                gvalid = 1'b1;
                gch    = CH_W'(idx);
            end
        end
    end

    always_comb begin
        pop = '0;
        if (step && gvalid) pop[gch] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                 ptr <= CH_W'(NCH-1);
        else if (step && gvalid) ptr <= gch;
    end

    assert_pop_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop));
    assert_idle_no_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (nonempty == '0) |-> (pop == '0));
endmodule

// File: rtl/pkt_serializer.sv
module pkt_serializer #(
    parameter int WORD_W = tr_pkg::WORD_WD,
    parameter int PKT_W  = tr_pkg::PKT_WD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              ready,
    output logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_valid
);
    localparam int NPKT = WORD_W / PKT_W;
    localparam int CW   = $clog2(NPKT + 1);

    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     left;

    assign ready     = (left <= CW'(1));
    assign pkt_valid = (left != '0);
    assign pkt_data  = pkt_valid ? shreg[WORD_W-1 -: PKT_W] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            left  <= '0;
        end else if (load) begin
            shreg <= word;
            left  <= CW'(NPKT);
        end else if (left != '0) begin
            shreg <= shreg << PKT_W;
            left  <= left - 1'b1;
        end
    end

    assert_load_when_ready_R10: assert property (@(posedge clk) disable iff (rst)
        load |-> ready);
    assert_marker_first_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (pkt_valid && pkt_data[PKT_W-1]));
    assert_burst_contiguous_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !ready) |=> pkt_valid);
endmodule

// File: rtl/token_readout.sv
module token_readout #(
    parameter int NCH     = tr_pkg::NCH_D,
    parameter int STAMP_W = tr_pkg::STAMP_WD,
    parameter int DEPTH   = tr_pkg::DEPTH_D,
    parameter int PKT_W   = tr_pkg::PKT_WD
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   core_tick,
    input  logic [NCH-1:0]         wr_en,
    input  logic [NCH*STAMP_W-1:0] wr_stamp,
    output logic [PKT_W-1:0]       pkt_data,
    output logic                   pkt_valid,
    output logic [NCH-1:0]         fifo_full,
    output logic [NCH-1:0]         ovf_flag
);
    import tr_pkg::*;
    localparam int CH_W = $clog2(NCH);

    logic [STAMP_W-1:0] rdata [NCH];
    logic [NCH-1:0]     empty, pop;
    logic               ser_ready, step, gvalid;
    logic [CH_W-1:0]    gch;
    hit_word_t          word;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_fifo #(.DEPTH(DEPTH), .W(STAMP_W)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .wr    (core_tick && wr_en[c]),
            .wdata (wr_stamp[c*STAMP_W +: STAMP_W]),
            .rd    (pop[c]),
            .rdata (rdata[c]),
            .empty (empty[c]),
            .full  (fifo_full[c]),
            .ovf   (ovf_flag[c])
        );
    end

    assign step = core_tick && ser_ready;

    token_arbiter #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .nonempty (~empty),
        .pop      (pop),
        .gvalid   (gvalid),
        .gch      (gch)
    );

    assign word = pack_hit(gch, rdata[gch]);

    pkt_serializer #(.WORD_W(WORD_WD), .PKT_W(PKT_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (step && gvalid),
        .word      (word),
        .ready     (ser_ready),
        .pkt_data  (pkt_data),
        .pkt_valid (pkt_valid)
    );

    assert_pop_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (pop != '0) |-> core_tick);
endmodule

// File: tb/sim_token_readout.sv
module sim_token_readout;
    localparam int NCH = 32;
    localparam int SW  = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              core_tick = 1'b0;
    logic [NCH-1:0]    wr_en = '0;
    logic [NCH*SW-1:0] wr_stamp = '0;
    logic [7:0]        pkt_data;
    logic              pkt_valid;
    logic [NCH-1:0]    fifo_full, ovf_flag;

    always #4 clk = ~clk;

    token_readout u0 (
        .clk(clk), .rst(rst), .core_tick(core_tick), .wr_en(wr_en),
        .wr_stamp(wr_stamp), .pkt_data(pkt_data), .pkt_valid(pkt_valid),
        .fifo_full(fifo_full), .ovf_flag(ovf_flag)
    );

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    logic [SW-1:0] mq [NCH][$];
    logic [31:0]   expq [$];
    bit            movf [NCH];
    int            mptr = NCH - 1;
    int            rem = 0;
    int            seq = 0;
    logic [31:0]   acc = '0;
    int            nb = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: rebuilds words from bytes and compares them in order.
    always @(negedge clk) begin
        if (!rst) begin
            if (pkt_valid) begin
                acc = {acc[23:0], pkt_data};
                nb++;
                if (nb == 4) begin
                    nb = 0;
                    if (expq.size() == 0) begin
                        chk(0, {"R4 unexpected word ", phase}, acc, 32'h0);
                    end else begin
                        logic [31:0] e;
                        e = expq.pop_front();
                        chk(acc == e, {"R2 R5 R6 word ", phase}, acc, e);
                    end
                end
            end else begin
                chk(nb == 0, "R9 burst broken", 32'(nb), 32'h0);
                chk(pkt_data == 8'h00, "R3 idle bus", {24'h0, pkt_data}, 32'h0);
                nb = 0;
            end
        end
    end

    // Driver: checks flags, drives inputs, advances the reference model.
    task automatic cycle(input bit ce, input logic [NCH-1:0] we);
        logic [NCH-1:0] efull, eovf;
        bit fullb [NCH];
        bit loaded;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            efull[c] = (mq[c].size() == 4);
            eovf[c]  = movf[c];
        end
        chk(fifo_full == efull, {"R7 full flags ", phase}, fifo_full, efull);
        chk(ovf_flag == eovf, {"R8 overflow flags ", phase}, ovf_flag, eovf);
        core_tick = ce;
        wr_en     = ce ? we : '0;
        for (int c = 0; c < NCH; c++)
            wr_stamp[c*SW +: SW] = SW'(c * 37 + seq * 101 + 5);
        seq++;
        loaded = 0;
        for (int c = 0; c < NCH; c++) fullb[c] = (mq[c].size() == 4);
        if (ce && rem <= 1) begin
            for (int i = 1; i <= NCH; i++) begin
                int idx;
                idx = (mptr + i) % NCH;
                if (!loaded && mq[idx].size() != 0) begin
                    logic [SW-1:0] st;
                    st = mq[idx].pop_front();
                    expq.push_back({1'b1, 5'(idx), 2'b00, st, 10'h0});
                    mptr = idx;
                    loaded = 1;
                end
            end
        end
        rem = loaded ? 4 : ((rem > 0) ? rem - 1 : 0);
        if (ce) begin
            for (int c = 0; c < NCH; c++) begin
                if (we[c]) begin
                    if (fullb[c]) movf[c] = 1;
                    else mq[c].push_back(wr_stamp[c*SW +: SW]);
                end
            end
        end
    endtask

    task automatic tick(input logic [NCH-1:0] we);
        cycle(1, we);
        repeat (3) cycle(0, '0);
    endtask

    task automatic idle(input int n);
        repeat (n) tick('0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(pkt_valid == 1'b0, "R1 valid after reset", {31'h0, pkt_valid}, 32'h0);
        chk(pkt_data == 8'h00, "R1 data after reset", {24'h0, pkt_data}, 32'h0);
        chk(fifo_full == '0, "R1 full after reset", fifo_full, 32'h0);
        chk(ovf_flag == '0, "R1 overflow after reset", ovf_flag, 32'h0);

        phase = "R3"; idle(8);
        phase = "R2"; tick(32'h1 << 5); idle(2);
        phase = "R5"; tick((32'h1 << 3) | (32'h1 << 17) | (32'h1 << 30)); idle(4);
        tick(32'h8000_0001); idle(3);

        phase = "R6 R7 R8";
        repeat (12) tick((32'h1 << 9) | (32'h1 << 10));
        @(negedge clk);
        chk(ovf_flag[9] == 1'b1, "R8 drop on full ch9", {31'h0, ovf_flag[9]}, 32'h1);
        chk(fifo_full[10] == 1'b1, "R7 ch10 full", {31'h0, fifo_full[10]}, 32'h1);
        idle(12);

        phase = "R10";
        foreach (expq[i]) begin end
        for (int k = 0; k < 12; k++) begin
            int gap;
            gap = (k % 4 == 0) ? 1 : (k % 4 == 1) ? 2 : (k % 4 == 2) ? 3 : 5;
            cycle(1, (32'h1 << ((k * 7) % 32)) | 32'h0000_4000);
            repeat (gap - 1) cycle(0, '0);
        end
        idle(20);

        phase = "R4"; tick('1); idle(40);
        @(negedge clk);
        chk(expq.size() == 0, "R4 all hits delivered", 32'(expq.size()), 32'h0);
        chk(nb == 0, "R9 no partial word", 32'(nb), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule